// File: doc/BRIEF.md
# Look-Aside Snooping Cache

This block is a small data cache that hangs off a shared synchronous bus next to the main memory. It does not sit in the path between the processor and memory. When a cycle starts on a cacheable address, it stalls the bus for one clock through an active-low wait line while it compares tags. On a read hit it supplies the word and ends the cycle itself. On a miss it drops wait, lets the memory device answer, and copies the returned word into the line.

Every bus master's writes pass the block, including those of a DMA engine. A write that hits a held line updates that line, so software never needs to flush the cache after a transfer. Addresses outside the single cacheable memory window pass through with no stall and are never allocated. A flush input invalidates the whole store. If the flush arrives in the middle of a bus cycle, the invalidation waits until that cycle has ended.

Top module: `look_aside_cache`

## Requirements
- R1: After reset every line is invalid, `bus_wait_no` is high, and `cache_ack_o` and `cache_oe_o` are low.
- R2: A strobe in idle on a cacheable address drives `bus_wait_no` low for exactly the one clock that follows the strobe clock.
- R3: A read hit raises `cache_ack_o` and `cache_oe_o` for one clock, in the clock after the wait clock, with the cached word on `cache_data_o`. The memory device does not take part.
- R4: On a cacheable read miss, wait is released after the lookup clock and the memory completes the cycle. The word on `bus_data_i` when `mem_ack_i` is high fills the line, so the next read of that address hits.
- R5: A cacheable write from any master that hits a held line replaces its word with the data present at `mem_ack_i`. The memory still completes the write.
- R6: A cacheable write that misses allocates nothing, so a later read of that address misses.
- R7: Only addresses 0x200000 to 0x9FFFFF are cacheable. Every other address, including the I/O windows 0xA00000 to 0xB7FFFF and 0xE80000 to 0xEFFFFF, never drives wait low and is never allocated.
- R8: The cache is direct-mapped, with 64 one-word lines indexed by address bits [7:2] and tagged by bits [23:8]. Two addresses that differ only in the tag evict each other.
- R9: A flush pulse while the bus is idle invalidates all lines.
- R10: A lookup in the same clock as a flush pulse, or while a flush is pending, is reported as a miss. A flush raised during a bus cycle invalidates all lines once that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 24 | Byte address, valid with the strobe |
| bus_rd_i | input | 1 | 1 = read, 0 = write, valid with the strobe |
| bus_as_i | input | 1 | One-clock address strobe that starts a cycle |
| bus_data_i | input | 32 | Bus data as driven by the memory (reads) or the master (writes) |
| mem_ack_i | input | 1 | Memory device acknowledge that ends the cycle |
| flush_i | input | 1 | Invalidate-all request pulse |
| bus_wait_no | output | 1 | Active-low wait, held low during the lookup clock |
| cache_ack_o | output | 1 | Cycle termination by the cache on a read hit |
| cache_data_o | output | 32 | Hit data, zero when not driving |
| cache_oe_o | output | 1 | Enable for the cache's data drivers |

## Verification
The hardest case to reach from the ports is a flush that lands exactly in the lookup clock of a read to a line that is valid. To create it, the bench first fills a line. It then starts a read to that line and raises `flush_i` at the same falling edge where it first sees wait low. The read must then complete from memory, and the read that follows must miss as well. The bench also places reads at both ends of the cacheable window and uses two addresses that map to the same index to force evictions.

// File: rtl/lac_pkg.sv
package lac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_HIT, ST_MEM} lac_state_e;
endpackage

// File: rtl/lac_region.sv
module lac_region #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h20_0000,
  parameter logic [ADDR_W-1:0] MEM_SIZE = 24'h80_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cacheable_o
);
  localparam logic [ADDR_W:0] LIMIT = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};

  assign cacheable_o = (addr_i >= MEM_BASE) && ({1'b0, addr_i} < LIMIT);
endmodule

// File: rtl/lac_store.sv
module lac_store #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LINES  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inv_all_i
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] word_q [LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = addr_i[OFF_W +: IDX_W];
  assign tag = addr_i[ADDR_W-1 -: TAG_W];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          valid_q[g] <= 1'b0;
      else if (inv_all_i)                   valid_q[g] <= 1'b0;
      else if (wr_en_i && idx == IDX_W'(g)) valid_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx]  <= tag;
      word_q[idx] <= wr_data_i;
    end
  end

  assign hit_o  = valid_q[idx] && (tag_q[idx] == tag);
  assign data_o = word_q[idx];

  // R9: invalidate-all leaves no valid line
  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i && !wr_en_i |=> valid_q == '0);
endmodule

// File: rtl/lac_ctrl.sv
module lac_ctrl
  import lac_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_as_i,
  input  logic              mem_ack_i,
  input  logic              flush_i,
  input  logic              cacheable_i,
  input  logic              store_hit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic              inv_all_o,
  output logic              bus_wait_no,
  output logic              cache_ack_o
);
  lac_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, cach_q, flush_pend_q;
  logic              lookup_hit;

  // a flush in flight forbids any hit
  assign lookup_hit = (state_q == ST_LOOK) && rd_q && store_hit_i && !flush_i && !flush_pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (bus_as_i) state_d = cacheable_i ? ST_LOOK : ST_MEM;
      ST_LOOK: state_d = lookup_hit ? ST_HIT : ST_MEM;
      ST_HIT:  state_d = ST_IDLE;
      ST_MEM:  if (mem_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      rd_q         <= 1'b0;
      cach_q       <= 1'b0;
      flush_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && bus_as_i) begin
        addr_q <= bus_addr_i;
        rd_q   <= bus_rd_i;
        cach_q <= cacheable_i;
      end
      if (state_q == ST_IDLE)  flush_pend_q <= 1'b0;
      else if (flush_i)        flush_pend_q <= 1'b1;
    end
  end

  assign addr_o      = addr_q;
  assign inv_all_o   = (state_q == ST_IDLE) && (flush_i || flush_pend_q);
  // fill on read miss, update on write hit
  assign wr_en_o     = (state_q == ST_MEM) && mem_ack_i && cach_q && (rd_q || store_hit_i);
  assign bus_wait_no = (state_q != ST_LOOK);
  assign cache_ack_o = (state_q == ST_HIT);

  a_r2_wait_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wait_no |=> bus_wait_no);
  a_r2_wait_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && bus_as_i && cacheable_i |=> !bus_wait_no);
  a_r7_io_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && bus_as_i && !cacheable_i |=> bus_wait_no);
  a_r3_hit_after_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_ack_o |-> $past(!bus_wait_no));
  a_r10_no_stale_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wait_no && flush_i |=> !cache_ack_o);
endmodule

// File: rtl/look_aside_cache.sv
module look_aside_cache #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h20_0000,
  parameter logic [ADDR_W-1:0] MEM_SIZE = 24'h80_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_as_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              mem_ack_i,
  input  logic              flush_i,
  output logic              bus_wait_no,
  output logic              cache_ack_o,
  output logic [DATA_W-1:0] cache_data_o,
  output logic              cache_oe_o
);
  logic              cacheable, store_hit, wr_en, inv_all;
  logic [ADDR_W-1:0] look_addr;
  logic [DATA_W-1:0] store_data;

  lac_region #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_region (
    .addr_i      (bus_addr_i),
    .cacheable_o (cacheable)
  );

  lac_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_as_i    (bus_as_i),
    .mem_ack_i   (mem_ack_i),
    .flush_i     (flush_i),
    .cacheable_i (cacheable),
    .store_hit_i (store_hit),
    .addr_o      (look_addr),
    .wr_en_o     (wr_en),
    .inv_all_o   (inv_all),
    .bus_wait_no (bus_wait_no),
    .cache_ack_o (cache_ack_o)
  );

  lac_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (look_addr),
    .hit_o     (store_hit),
    .data_o    (store_data),
    .wr_en_i   (wr_en),
    .wr_data_i (bus_data_i),
    .inv_all_i (inv_all)
  );

  assign cache_oe_o   = cache_ack_o;
  assign cache_data_o = cache_ack_o ? store_data : '0;
endmodule

// File: tb/look_aside_cache_test.sv
`timescale 1ns/1ps
module look_aside_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        rd = 1'b0, as_s = 1'b0, mack = 1'b0, flush = 1'b0;
  logic [31:0] bdata = '0;
  logic        wait_n, cack, coe;
  logic [31:0] cdata;

  always #2.5 clk = ~clk;

  look_aside_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_as_i(as_s),
    .bus_data_i(bdata), .mem_ack_i(mack), .flush_i(flush),
    .bus_wait_no(wait_n), .cache_ack_o(cack), .cache_data_o(cdata), .cache_oe_o(coe)
  );

  typedef struct {
    string       tag;
    logic [31:0] data;
    logic        hit;
    int          waits;
    logic        chk_data;
  } item_t;

  item_t exp_q[$];
  item_t act_q[$];
  logic [31:0] mem [int];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] mem_rd(logic [23:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {8'h5A, a};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: pushes the expectation, runs the cycle, records what was seen
  task automatic bus_cycle(string tag, logic [23:0] a, logic r, logic [31:0] wd,
                           logic exp_hit, int exp_waits, bit flush_at_look);
    item_t e, o;
    e.tag = tag; e.hit = exp_hit; e.waits = exp_waits; e.chk_data = r;
    e.data = r ? mem_rd(a) : wd;
    exp_q.push_back(e);
    o.tag = tag; o.waits = 0; o.hit = 0; o.data = '0; o.chk_data = r;
    @(negedge clk);
    addr = a; rd = r; as_s = 1'b1; bdata = r ? 32'h0 : wd;
    @(negedge clk);
    as_s = 1'b0;
    forever begin
      if (!wait_n) begin
        o.waits++;
        if (flush_at_look) flush = 1'b1;
      end
      if (cack) begin
        o.hit = 1'b1; o.data = cdata;
        break;
      end else if (wait_n) begin
        mack = 1'b1;
        bdata = r ? mem_rd(a) : wd;
        if (!r) mem[int'(a)] = wd;
        o.data = bdata;
        @(negedge clk);
        mack = 1'b0; flush = 1'b0;
        break;
      end
      @(negedge clk);
      flush = 1'b0;
    end
    act_q.push_back(o);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      item_t e, o;
      wait (act_q.size() > 0);
      o = act_q.pop_front();
      e = exp_q.pop_front();
      check({e.tag, " hit"}, {31'b0, o.hit}, {31'b0, e.hit});
      check({e.tag, " waits"}, o.waits, e.waits);
      if (e.chk_data) check({e.tag, " data"}, o.data, e.data);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [23:0] A = 24'h20_0040;
  localparam logic [23:0] B = 24'h30_0080;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wait idle", {31'b0, wait_n}, 32'd1);
    check("R1 ack idle", {31'b0, cack}, 32'd0);
    check("R1 oe idle", {31'b0, coe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wait after release", {31'b0, wait_n}, 32'd1);

    bus_cycle("R1 R4 first read miss", A, 1, 0, 0, 1, 0);
    bus_cycle("R3 R2 read hit", A, 1, 0, 1, 1, 0);
    bus_cycle("R5 write hit", A, 0, 32'hDEAD_BEEF, 0, 1, 0);
    bus_cycle("R5 read updated", A, 1, 0, 1, 1, 0);
    bus_cycle("R6 write miss", B, 0, 32'h1111_2222, 0, 1, 0);
    bus_cycle("R6 read after write miss", B, 1, 0, 0, 1, 0);
    bus_cycle("R4 read refilled", B, 1, 0, 1, 1, 0);
    bus_cycle("R7 io read", 24'hE8_0010, 1, 0, 0, 0, 0);
    bus_cycle("R7 io read again", 24'hE8_0010, 1, 0, 0, 0, 0);
    bus_cycle("R7 io low edge", 24'hA0_0000, 1, 0, 0, 0, 0);
    bus_cycle("R7 io high edge", 24'hB7_FFFC, 1, 0, 0, 0, 0);
    bus_cycle("R7 top of window", 24'h9F_FFFC, 1, 0, 0, 1, 0);
    bus_cycle("R7 top of window hit", 24'h9F_FFFC, 1, 0, 1, 1, 0);
    bus_cycle("R7 below window", 24'h1F_FFFC, 1, 0, 0, 0, 0);
    bus_cycle("R8 conflict fill", A + 24'h100, 1, 0, 0, 1, 0);
    bus_cycle("R8 evicted", A, 1, 0, 0, 1, 0);
    bus_cycle("R8 refill hit", A, 1, 0, 1, 1, 0);

    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    bus_cycle("R9 flush clears A", A, 1, 0, 0, 1, 0);
    bus_cycle("R9 flush clears B", B, 1, 0, 0, 1, 0);
    bus_cycle("R10 setup hit", A, 1, 0, 1, 1, 0);
    bus_cycle("R10 flush at lookup", A, 1, 0, 0, 1, 1);
    bus_cycle("R10 after deferred flush", A, 1, 0, 0, 1, 0);
    bus_cycle("R10 refill hit", A, 1, 0, 1, 1, 0);

    wait (act_q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule